// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is an event timer mapped into a 1024-byte register window. A single free-running main counter is shared by a parameterised number of comparator channels. Each channel watches the counter and, when the counter reaches its deadline, raises an interrupt. The interrupt is either a one-cycle pulse (edge) or a sticky status bit that software must clear (level). A channel can be one-shot: it fires once and is re-armed by writing a new deadline. A channel that reports the periodic capability can also be periodic: the deadline moves forward by a hidden period register on every match.

Software first loads the counter, which it may only do while the counter is stopped, and then starts it. It then programs each channel's configuration and compare registers. Every 64-bit quantity appears as two 32-bit words, with the low word at the lower address. Each channel can be forced to a 32-bit mode, in which only the low half of the counter and of its compare and period registers take part.

Top module: `evt_timer`

## Requirements
- R1: The word at byte offset 0x000 reports the channel count minus one in bits [4:0] and, in bit 8, a 1 when the counter is 64 bits wide. The word at 0x004 reports the tick period in femtoseconds. Writes to either word are ignored.
- R2: The main counter reads at 0x0F0 (low word) and 0x0F4 (high word). It advances by one per clock only while bit 0 of the general configuration word at 0x010 is 1. Writes to the counter take effect only while that bit is 0.
- R3: After reset, the general configuration, the status word and every channel's writable configuration bits read 0, the counter reads 0, every compare word reads 0xFFFFFFFF, and no interrupt is asserted.
- R4: Channel N occupies 0x100+0x20*N. Its configuration word at +0x0 holds bit 1 level type, bit 2 interrupt enable, bit 3 periodic, bit 4 periodic-capable (read-only), bit 6 value-set and bit 8 32-bit mode. The word at +0x4 holds a read-only routing-capability value. Bit 3 cannot be set and reads 0 on a channel without the periodic capability.
- R5: A channel matches when the running counter equals its compare value (low word at +0x8, high word at +0xC). The interrupt becomes visible after the clock edge that moves the counter past that value. A one-shot channel fires once and keeps its compare value.
- R6: In level mode a match sets bit N of the status word at 0x020. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. The interrupt output is high while the status bit and the interrupt enable are both 1.
- R7: In edge mode a match with the interrupt enable set gives a single-cycle pulse on the interrupt output and leaves the status word unchanged.
- R8: With value-set armed, compare writes load the deadline, and the completing word write clears value-set. On a periodic channel, later compare writes load the hidden period. Each match adds the period to the compare value in the same cycle.
- R9: In 32-bit mode a match uses only the low 32 counter bits, writes to the compare high word are ignored, and the low-word write completes a compare write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; data appears after the edge |
| reg_addr_i | input | 10 | Byte address of a 32-bit word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CH | One interrupt line per channel |

## Verification
The bench builds the timer with three channels, a 64-bit counter and a periodic-capability mask of 3'b101. With this mask one channel lacks the capability, so the forced-zero periodic bit can be checked beside two capable channels. Because the counter is 64 bits wide, the 32-bit mode can be shown to match on the low half while the high halves differ. The counter is preloaded near a 32-bit boundary so that the low-half match, and a full-width match carried into the high word, both occur within a few dozen cycles.

// File: rtl/evt_pkg.sv
package evt_pkg;
  // byte offsets of shared words
  localparam logic [9:0] A_CAP_LO = 10'h000;
  localparam logic [9:0] A_CAP_HI = 10'h004;
  localparam logic [9:0] A_GCFG   = 10'h010;
  localparam logic [9:0] A_STAT   = 10'h020;
  localparam logic [9:0] A_CNT_LO = 10'h0F0;
  localparam logic [9:0] A_CNT_HI = 10'h0F4;
  // channel windows start at 0x100 with a 0x20 stride
  localparam int unsigned CH_FIRST = 8;
  localparam logic [2:0] SUB_CFG   = 3'd0;
  localparam logic [2:0] SUB_ROUTE = 3'd1;
  localparam logic [2:0] SUB_CMPL  = 3'd2;
  localparam logic [2:0] SUB_CMPH  = 3'd3;
  // channel configuration bit positions
  localparam int unsigned B_LEVEL = 1;
  localparam int unsigned B_IE    = 2;
  localparam int unsigned B_PER   = 3;
  localparam int unsigned B_PCAP  = 4;
  localparam int unsigned B_VSET  = 6;
  localparam int unsigned B_M32   = 8;
  localparam int unsigned B_WIDE  = 8;  // capability word: 64-bit counter

  typedef struct packed {
    logic m32;
    logic vset;
    logic per;
    logic ie;
    logic level;
  } ch_cfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [63:0]      wide;
  logic             cnt_en;

  always_comb begin
    wide   = 64'(cnt_q);
    cnt_en = run_i | wr_lo_i | wr_hi_i;
    cnt_d  = cnt_q;
    if (run_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      if (wr_lo_i) wide[31:0]  = wdata_i;
      if (wr_hi_i) wide[63:32] = wdata_i;
      cnt_d = CNT_W'(wide);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: counting step and hold
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter bit          PER_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic             cmp_we_lo_i,
  input  logic             cmp_we_hi_i,
  input  logic [31:0]      wdata_i,
  output ch_cfg_t          cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             pulse_o
);
  localparam bit WIDE = (CNT_W > 32);

  ch_cfg_t          cfg_q, cfg_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d;
  logic             pulse_q, pulse_d;
  logic             hi_ok, wr_any, wr_done, to_period, hit;
  logic             cfg_en, cmp_en, per_en;
  logic [63:0]      cmp_w, per_w, cur, inc, cmp_sum;

  always_comb begin
    hi_ok     = WIDE && !cfg_q.m32;
    wr_any    = cmp_we_lo_i | (cmp_we_hi_i & hi_ok);
    wr_done   = hi_ok ? cmp_we_hi_i : cmp_we_lo_i;
    to_period = cfg_q.per && !cfg_q.vset;
    hit       = tick_i && (cfg_q.m32 ? (cnt_i[31:0] == cmp_q[31:0]) : (cnt_i == cmp_q));

    cur   = 64'(cmp_q);
    inc   = 64'(per_q);
    cmp_w = cur;
    per_w = inc;
    if (cmp_we_lo_i) begin
      if (to_period) per_w[31:0] = wdata_i;
      else           cmp_w[31:0] = wdata_i;
    end
    if (cmp_we_hi_i && hi_ok) begin
      if (to_period) per_w[63:32] = wdata_i;
      else           cmp_w[63:32] = wdata_i;
    end
    cmp_sum = cfg_q.m32 ? {cur[63:32], cur[31:0] + inc[31:0]} : (cur + inc);

    per_d  = CNT_W'(per_w);
    per_en = wr_any && to_period;
    cmp_d  = cmp_q;
    cmp_en = 1'b0;
    if (wr_any && !to_period) begin
      cmp_d  = CNT_W'(cmp_w);
      cmp_en = 1'b1;
    end else if (hit && cfg_q.per) begin
      cmp_d  = CNT_W'(cmp_sum);
      cmp_en = 1'b1;
    end

    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (cfg_we_i) begin
      cfg_d.level = wdata_i[B_LEVEL];
      cfg_d.ie    = wdata_i[B_IE];
      cfg_d.per   = wdata_i[B_PER] & PER_CAP;
      cfg_d.vset  = wdata_i[B_VSET];
      cfg_d.m32   = wdata_i[B_M32];
      cfg_en      = 1'b1;
    end else if (wr_done && cfg_q.vset) begin
      cfg_d.vset = 1'b0;
      cfg_en     = 1'b1;
    end

    pulse_d = hit && cfg_q.ie && !cfg_q.level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (cmp_en) cmp_q <= cmp_d;
      if (per_en) per_q <= per_d;
      pulse_q <= pulse_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign cmp_o   = cmp_q;
  assign hit_o   = hit;
  assign pulse_o = pulse_q;

  // R8: periodic reload adds the period on a match
  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cfg_q.per && !wr_any && !cfg_q.m32) |=> cmp_q == $past(cmp_q) + $past(per_q));
  // R8: value-set disarms on the completing word
  a_r8_vset_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.vset && wr_done && !cfg_we_i) |=> !cfg_q.vset);
  // R5: a one-shot match keeps the deadline
  a_r5_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !cfg_q.per && !wr_any) |=> $stable(cmp_q));
  // R4: periodic only where the capability exists
  a_r4_per_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.per |-> PER_CAP);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int unsigned          NUM_CH    = 3,   // 1..24 fits the window
  parameter int unsigned          CNT_W     = 64,  // 32 or 64
  parameter logic [NUM_CH-1:0]    PER_CAP   = '1,
  parameter logic [31:0]          ROUTE_CAP = 32'h0000_0C00,
  parameter logic [31:0]          TICK_FS   = 32'd69841279
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [9:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam bit          WIDE   = (CNT_W > 32);
  localparam logic [31:0] CAP_LO = 32'(NUM_CH - 1) | (WIDE ? (32'd1 << B_WIDE) : 32'd0);

  logic [1:0]        rs_q;
  logic              rst_n;
  logic              run_q, run_d, run_en;
  logic [NUM_CH-1:0] sts_q, sts_d, sts_set, sts_clr;
  logic              sts_wr, aligned;
  logic [31:0]       rd_q, rd_d;
  logic [CNT_W-1:0]  cnt;
  logic [63:0]       cnt64;
  logic              cnt_wr_lo, cnt_wr_hi;
  logic [NUM_CH-1:0] sel, cfg_we, lo_we, hi_we, hit, pulse;
  ch_cfg_t           cfg [NUM_CH];
  logic [CNT_W-1:0]  cmp [NUM_CH];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign aligned   = (reg_addr_i[1:0] == 2'b00);
  assign cnt_wr_lo = reg_wr_i && (reg_addr_i == A_CNT_LO) && !run_q;
  assign cnt_wr_hi = reg_wr_i && (reg_addr_i == A_CNT_HI) && !run_q;
  assign sts_wr    = reg_wr_i && (reg_addr_i == A_STAT);

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (run_q),
    .wr_lo_i (cnt_wr_lo),
    .wr_hi_i (cnt_wr_hi),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt)
  );
  assign cnt64 = 64'(cnt);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign sel[n]    = aligned && (reg_addr_i[9:5] == 5'(CH_FIRST + n));
    assign cfg_we[n] = reg_wr_i && sel[n] && (reg_addr_i[4:2] == SUB_CFG);
    assign lo_we[n]  = reg_wr_i && sel[n] && (reg_addr_i[4:2] == SUB_CMPL);
    assign hi_we[n]  = reg_wr_i && sel[n] && (reg_addr_i[4:2] == SUB_CMPH);

    evt_channel #(.CNT_W(CNT_W), .PER_CAP(PER_CAP[n])) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .tick_i      (run_q),
      .cnt_i       (cnt),
      .cfg_we_i    (cfg_we[n]),
      .cmp_we_lo_i (lo_we[n]),
      .cmp_we_hi_i (hi_we[n]),
      .wdata_i     (reg_wdata_i),
      .cfg_o       (cfg[n]),
      .cmp_o       (cmp[n]),
      .hit_o       (hit[n]),
      .pulse_o     (pulse[n])
    );

    assign sts_set[n] = hit[n] && cfg[n].level;
    assign irq_o[n]   = cfg[n].ie && (cfg[n].level ? sts_q[n] : pulse[n]);
  end

  always_comb begin
    sts_clr = sts_wr ? reg_wdata_i[NUM_CH-1:0] : '0;
    sts_d   = (sts_q & ~sts_clr) | sts_set;
    run_en  = reg_wr_i && (reg_addr_i == A_GCFG);
    run_d   = reg_wdata_i[0];
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr_i)
      A_CAP_LO: rd_d = CAP_LO;
      A_CAP_HI: rd_d = TICK_FS;
      A_GCFG:   rd_d = {31'd0, run_q};
      A_STAT:   rd_d = 32'(sts_q);
      A_CNT_LO: rd_d = cnt64[31:0];
      A_CNT_HI: rd_d = cnt64[63:32];
      default:  rd_d = '0;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel[n]) begin
        case (reg_addr_i[4:2])
          SUB_CFG: begin
            rd_d[B_LEVEL] = cfg[n].level;
            rd_d[B_IE]    = cfg[n].ie;
            rd_d[B_PER]   = cfg[n].per;
            rd_d[B_PCAP]  = PER_CAP[n];
            rd_d[B_VSET]  = cfg[n].vset;
            rd_d[B_M32]   = cfg[n].m32;
          end
          SUB_ROUTE: rd_d = ROUTE_CAP;
          SUB_CMPL:  rd_d = 64'(cmp[n]) >> 0 == 0 ? 32'd0 : 32'(64'(cmp[n]));
          SUB_CMPH:  rd_d = 32'(64'(cmp[n]) >> 32);
          default:   rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sts_q <= '0;
      rd_q  <= '0;
    end else begin
      if (run_en)   run_q <= run_d;
      sts_q <= sts_d;
      if (reg_rd_i) rd_q  <= rd_d;
    end
  end

  assign reg_rdata_o = rd_q;

  // R6: a status bit only falls through a write of 1
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sts_wr |=> (($past(sts_q) & ~sts_q) == '0));
  // R7: edge-mode channels never touch the status word
  a_r7_no_status: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sts_wr && ((sts_set & ~sts_q) == '0)) |=> $stable(sts_q));
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int          NCH     = 3;
  localparam logic [31:0] TB_TICK  = 32'd69841279;
  localparam logic [31:0] TB_ROUTE = 32'h0000_0C00;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // register table: reset values (R3), capabilities (R1), config bits (R4), counter load (R2)
  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'h000, 32'h0000_0102, 4'd1},
    '{1'b0, 10'h004, TB_TICK,       4'd1},
    '{1'b0, 10'h010, 32'h0,         4'd3},
    '{1'b0, 10'h020, 32'h0,         4'd3},
    '{1'b0, 10'h0F0, 32'h0,         4'd3},
    '{1'b0, 10'h0F4, 32'h0,         4'd3},
    '{1'b0, 10'h108, 32'hFFFF_FFFF, 4'd3},
    '{1'b0, 10'h14C, 32'hFFFF_FFFF, 4'd3},
    '{1'b0, 10'h100, 32'h0000_0010, 4'd4},
    '{1'b0, 10'h120, 32'h0000_0000, 4'd4},
    '{1'b0, 10'h140, 32'h0000_0010, 4'd4},
    '{1'b0, 10'h124, TB_ROUTE,      4'd4},
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 4'd1},
    '{1'b0, 10'h000, 32'h0000_0102, 4'd1},
    '{1'b1, 10'h124, 32'hFFFF_FFFF, 4'd4},
    '{1'b0, 10'h124, TB_ROUTE,      4'd4},
    '{1'b1, 10'h120, 32'hFFFF_FFFF, 4'd4},
    '{1'b0, 10'h120, 32'h0000_0146, 4'd4},
    '{1'b1, 10'h120, 32'h0,         4'd4},
    '{1'b0, 10'h120, 32'h0,         4'd4},
    '{1'b1, 10'h100, 32'h0000_0008, 4'd4},
    '{1'b0, 10'h100, 32'h0000_0018, 4'd4},
    '{1'b1, 10'h100, 32'h0,         4'd4},
    '{1'b0, 10'h100, 32'h0000_0010, 4'd4},
    '{1'b1, 10'h0F0, 32'h1122_3344, 4'd2},
    '{1'b1, 10'h0F4, 32'h5566_7788, 4'd2},
    '{1'b0, 10'h0F0, 32'h1122_3344, 4'd2},
    '{1'b0, 10'h0F4, 32'h5566_7788, 4'd2},
    '{1'b1, 10'h0F0, 32'h0,         4'd2},
    '{1'b1, 10'h0F4, 32'h0,         4'd2}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [9:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] irq;
  int             checks = 0, fails = 0;
  bit             done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  evt_timer #(
    .NUM_CH(NCH), .CNT_W(64), .PER_CAP(3'b101),
    .ROUTE_CAP(TB_ROUTE), .TICK_FS(TB_TICK)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; uses exactly one rising edge
  task automatic wreg(input logic [9:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [9:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic stop_and_zero();
    wreg(10'h010, 32'h0);
    wreg(10'h0F0, 32'h0);
    wreg(10'h0F4, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int miss, pulses;
    repeat (3) @(negedge clk);
    check(32'(irq), 32'h0, 3, "irq in reset");               // R3
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wreg(TBL[i].addr, TBL[i].data);
      else begin
        rreg(TBL[i].addr, v);
        check(v, TBL[i].data, int'(TBL[i].req), $sformatf("table row %0d", i));
      end
    end

    // R2: counting, write blocking while running, stopping
    wreg(10'h010, 32'h1);                       // E0
    rreg(10'h0F0, v); check(v, 32'd0, 2, "count E1");
    rreg(10'h0F0, v); check(v, 32'd1, 2, "count E2");
    wreg(10'h0F0, 32'hABC);                     // E3 ignored
    rreg(10'h0F0, v); check(v, 32'd3, 2, "write while running ignored");
    wreg(10'h010, 32'h0);                       // E5
    rreg(10'h0F0, v); check(v, 32'd5, 2, "stop value");
    rreg(10'h0F0, v); check(v, 32'd5, 2, "held while stopped");
    wreg(10'h0F0, 32'h0);
    rreg(10'h0F0, v); check(v, 32'd0, 2, "load while stopped");

    // R5 / R6: one-shot level on channel 1
    wreg(10'h120, 32'h6);
    wreg(10'h128, 32'd20);
    wreg(10'h12C, 32'd0);
    check(32'(irq[1]), 32'h0, 5, "no irq before start");
    wreg(10'h010, 32'h1);                       // E0
    repeat (20) @(negedge clk);
    check(32'(irq[1]), 32'h0, 5, "irq low after E20");
    @(negedge clk);
    check(32'(irq[1]), 32'h1, 5, "irq high after E21");
    wreg(10'h020, 32'h0);                       // R6 write 0 keeps
    rreg(10'h020, v); check(v, 32'h2, 6, "status set, write 0 no effect");
    check(32'(irq[1]), 32'h1, 6, "level held");
    wreg(10'h020, 32'h2);
    check(32'(irq[1]), 32'h0, 6, "write 1 clears");
    repeat (40) @(negedge clk);
    check(32'(irq[1]), 32'h0, 5, "one-shot fires once");
    rreg(10'h020, v); check(v, 32'h0, 5, "no second match");
    stop_and_zero();
    wreg(10'h120, 32'h0);

    // R8 / R7: periodic edge channel 0 with value-set
    wreg(10'h100, 32'h4C);
    rreg(10'h100, v); check(v, 32'h5C, 8, "value-set armed");
    wreg(10'h108, 32'd10);
    wreg(10'h10C, 32'd0);
    rreg(10'h100, v); check(v, 32'h1C, 8, "value-set cleared by completing write");
    wreg(10'h108, 32'd6);
    wreg(10'h10C, 32'd0);
    rreg(10'h108, v); check(v, 32'd10, 8, "period write leaves deadline");
    wreg(10'h010, 32'h1);                       // E0
    miss = 0; pulses = 0;
    for (int k = 1; k <= 40; k++) begin
      logic e;
      @(negedge clk);
      e = (k >= 11) && (((k - 11) % 6) == 0);
      if (irq[0] !== e) miss++;
      if (irq[0] === 1'b1) pulses++;
    end
    check(32'(miss), 32'd0, 8, "periodic pulse timing");
    check(32'(pulses), 32'd5, 7, "single-cycle pulses");
    rreg(10'h020, v); check(v, 32'h0, 7, "edge mode leaves status");
    stop_and_zero();
    wreg(10'h100, 32'h0);

    // R9: 32-bit mode on channel 2; R6 enable off on channel 1
    wreg(10'h0F0, 32'hFFFF_FFF0);
    wreg(10'h0F4, 32'h1);
    wreg(10'h140, 32'h106);
    wreg(10'h148, 32'hFFFF_FFF8);
    wreg(10'h14C, 32'h1234_5678);
    rreg(10'h14C, v); check(v, 32'hFFFF_FFFF, 9, "high word ignored in 32-bit mode");
    wreg(10'h120, 32'h2);
    wreg(10'h128, 32'hFFFF_FFFC);
    wreg(10'h12C, 32'h1);
    wreg(10'h010, 32'h1);                       // E0
    repeat (8) @(negedge clk);
    check(32'(irq[2]), 32'h0, 9, "low-half match not yet");
    @(negedge clk);
    check(32'(irq[2]), 32'h1, 9, "low-half match after E9");
    repeat (6) @(negedge clk);
    check(32'(irq[1]), 32'h0, 6, "enable off keeps irq low");
    rreg(10'h020, v); check(v, 32'h6, 6, "status from both level channels");

    // R3: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(32'(irq), 32'h0, 3, "irq cleared by reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rreg(10'h020, v); check(v, 32'h0, 3, "status after reset");
    rreg(10'h0F4, v); check(v, 32'h0, 3, "counter after reset");
    rreg(10'h148, v); check(v, 32'hFFFF_FFFF, 3, "compare after reset");
    rreg(10'h140, v); check(v, 32'h10, 3, "config after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule